// File: doc/BRIEF.md
# Aliased Timer Control Register File

This block holds two 64-bit timer control registers: the hypervisor counter control register and the kernel counter control register. It decodes system-register read and write requests aimed at them. Each request carries a five-field encoding (op0, op1, CRn, CRm, op2), the requester's privilege level (0 to 3), a write flag and write data. Three configuration inputs come with it: host mode, nested virtualization and level-2 enable.

The block checks whether the access is allowed. At level 2 in host mode it sends the kernel encoding to the hypervisor register. It drops reserved bits on writes and clears them on reads. One cycle after the request it returns a registered response carrying read data, an undefined-instruction flag, a trap-to-level-2 flag and a 6-bit syndrome class. An access that is undefined or trapped changes neither register. Everything else in the system-register space, and the entry into the exception, is left to the surrounding pipeline.

Top module: `tcr_file`

## Requirements
- R1: After reset, both registers read as zero, including the event-stream enable bit (bit 2) of the hypervisor register, and `rsp_valid` is low.
- R2: Every cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the following cycle. No response appears without a request.
- R3: At level 0, an access to either encoding responds undefined.
- R4: At level 1, an access to the hypervisor encoding (op0=3, op1=4, CRn=14, CRm=1, op2=0) traps with class 0x18 when `lvl2_enabled` and `nested_virt` are both 1. Otherwise it responds undefined.
- R5: At level 1, the kernel encoding (op0=3, op1=0, CRn=14, CRm=1, op2=0) reads and writes the kernel register.
- R6: At levels 2 and 3, the hypervisor encoding reads and writes the hypervisor register.
- R7: At level 2, the kernel encoding reaches the hypervisor register when `host_mode`=1 and the kernel register when `host_mode`=0.
- R8: At level 3, the kernel encoding always reaches the kernel register, whatever the value of `host_mode`.
- R9: For the hypervisor register, bits 63:12 are reserved when `host_mode`=1 and bits 63:8 are reserved when `host_mode`=0. The layout in force decides which bits a write drops and which bits a read returns as zero.
- R10: Bits 63:10 of the kernel register are reserved: writes drop them and reads return them as zero.
- R11: A request whose encoding matches neither register responds undefined.
- R12: An undefined or trapped access leaves both registers unchanged and returns zero read data. A write response also returns zero read data.
- R13: The undefined and trap flags are never both set, and the class is 0 in every response that does not trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_level | input | 2 | Privilege level of the requester (0 to 3) |
| req_wdata | input | 64 | Write data |
| host_mode | input | 1 | Host mode: selects the wide layout and the level-2 redirection |
| nested_virt | input | 1 | Nested virtualization: level-1 hypervisor access traps |
| lvl2_enabled | input | 1 | Level 2 is enabled in the current state |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read data, masked to the layout in force |
| rsp_undef | output | 1 | Access is undefined |
| rsp_trap | output | 1 | Access traps to level 2 |
| rsp_class | output | 6 | Syndrome class for a trap (0x18), else 0 |

## Verification
The assertions check on every cycle the following:
- each request gets exactly one response, one cycle later;
- level-0 requests come back undefined;
- a level-1 hypervisor access traps whenever nested virtualization and level 2 are both on;
- the two flags are exclusive, and the class appears only with a trap;
- a faulting response carries zero data, and the data never has a bit set above the widest layout;
- a register holds its value in any cycle it is not written.

Some behaviour only the bench's scenarios can show, because it needs a sequence of accesses:
- the routing of the kernel encoding to the right physical register at each level and host mode;
- write-then-read through the other encoding;
- the layout masks: a wide-layout write seen through the narrow layout, and bits dropped by a narrow-layout write that are later read through the wide one.

// File: rtl/tcr_pkg.sv
// Package: shared types and constants for the timer control register file.
// Assumes: privilege levels are encoded 0..3, and the trap class is 6 bits wide.
package tcr_pkg;

    localparam int CLASS_W = 6;

    typedef enum logic [1:0] {
        LVL_USER   = 2'd0,
        LVL_KERNEL = 2'd1,
        LVL_HYP    = 2'd2,
        LVL_MON    = 2'd3
    } priv_lvl_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_HYP  = 2'd1,
        TGT_KERN = 2'd2
    } target_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysreg_enc_t;

    typedef struct packed {
        target_e target;
        logic    undef;
        logic    trap;
    } route_t;

    localparam sysreg_enc_t ENC_HYPCTL  = '{op0: 2'd3, op1: 3'd4, crn: 4'd14, crm: 4'd1, op2: 3'd0};
    localparam sysreg_enc_t ENC_KERNCTL = '{op0: 2'd3, op1: 3'd0, crn: 4'd14, crm: 4'd1, op2: 3'd0};
    localparam logic [CLASS_W-1:0] CLASS_SYSREG_TRAP = 6'h18;

endpackage

// File: rtl/tcr_decode.sv
// Module: tcr_decode
// Combinational permission check and routing for one request. It decides
// which physical register (if any) the access reaches, or whether the access
// is undefined or traps to level 2.
// Assumes: the caller gates the result with its own request strobe.
module tcr_decode
    import tcr_pkg::*;
(
    input  sysreg_enc_t enc,
    input  logic [1:0]  level,
    input  logic        host_mode,
    input  logic        nested_virt,
    input  logic        lvl2_enabled,
    output route_t      route
);

    logic hit_hyp;
    logic hit_kern;
    priv_lvl_e lvl;

    assign hit_hyp  = (enc == ENC_HYPCTL);
    assign hit_kern = (enc == ENC_KERNCTL);
    assign lvl      = priv_lvl_e'(level);

    // Purpose: choose the target register, or the undefined/trap outcome, from encoding and level.
    always_comb begin
        route = '{target: TGT_NONE, undef: 1'b0, trap: 1'b0};
        if (!hit_hyp && !hit_kern) begin
            route.undef = 1'b1;
        end else if (lvl == LVL_USER) begin
            route.undef = 1'b1;
        end else if (hit_hyp) begin
            if (lvl == LVL_KERNEL) begin
                if (lvl2_enabled && nested_virt) route.trap  = 1'b1;
                else                             route.undef = 1'b1;
            end else begin
                route.target = TGT_HYP;
            end
        end else begin
            unique case (lvl)
                LVL_HYP: route.target = host_mode ? TGT_HYP : TGT_KERN;
                default: route.target = TGT_KERN;
            endcase
        end
    end

endmodule

// File: rtl/tcr_regbank.sv
// Module: tcr_regbank
// Storage for the hypervisor and kernel control registers. The write masks
// drop reserved bits. The read ports mask the hypervisor register with the
// layout in force (wide in host mode, narrow otherwise).
// Assumes: at most one of the two write enables is high in a cycle, and
// HOST_KEEP and BASE_KEEP are both below DATA_W.
module tcr_regbank #(
    parameter int DATA_W    = 64,
    parameter int HOST_KEEP = 12,
    parameter int BASE_KEEP = 8,
    parameter int KERN_KEEP = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hyp,
    input  logic              wr_kern,
    input  logic [DATA_W-1:0] wdata,
    input  logic              host_mode,
    output logic [DATA_W-1:0] hyp_rd,
    output logic [DATA_W-1:0] kern_rd
);

    localparam logic [DATA_W-1:0] HOST_MASK = {{(DATA_W-HOST_KEEP){1'b0}}, {HOST_KEEP{1'b1}}};
    localparam logic [DATA_W-1:0] BASE_MASK = {{(DATA_W-BASE_KEEP){1'b0}}, {BASE_KEEP{1'b1}}};

    logic [DATA_W-1:0] hyp_q;
    logic [DATA_W-1:0] kern_q;
    logic [DATA_W-1:0] hyp_mask;
    logic [DATA_W-1:0] kern_mask;

    assign hyp_mask = host_mode ? HOST_MASK : BASE_MASK;

    // Purpose: pick the kernel register mask; a full-width layout needs no mask.
    generate
        if (KERN_KEEP >= DATA_W) begin : g_kern_full
            assign kern_mask = '1;
        end else begin : g_kern_part
            assign kern_mask = {{(DATA_W-KERN_KEEP){1'b0}}, {KERN_KEEP{1'b1}}};
        end
    endgenerate

    // Purpose: hypervisor register; clears on reset (event enable included) and stores masked writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      hyp_q <= '0;
        else if (wr_hyp) hyp_q <= wdata & hyp_mask;
    end

    // Purpose: kernel register; clears on reset and stores masked writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       kern_q <= '0;
        else if (wr_kern) kern_q <= wdata & kern_mask;
    end

    assign hyp_rd  = hyp_q & hyp_mask;
    assign kern_rd = kern_q & kern_mask;

    AST_HYP_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !wr_hyp |=> $stable(hyp_q));   // R12
    AST_KERN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_kern |=> $stable(kern_q)); // R12

endmodule

// File: rtl/tcr_file.sv
// Module: tcr_file (top)
// Takes one-cycle system-register requests aimed at the two timer control
// registers. It decodes them, writes the allowed ones, and returns a
// registered response one cycle later.
// Assumes: requests are single-cycle strobes, and the configuration inputs are
// stable during the cycle a request is presented.
module tcr_file
    import tcr_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int HOST_KEEP = 12,
    parameter int BASE_KEEP = 8,
    parameter int KERN_KEEP = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_op0,
    input  logic [2:0]         req_op1,
    input  logic [3:0]         req_crn,
    input  logic [3:0]         req_crm,
    input  logic [2:0]         req_op2,
    input  logic [1:0]         req_level,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               host_mode,
    input  logic               nested_virt,
    input  logic               lvl2_enabled,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_undef,
    output logic               rsp_trap,
    output logic [CLASS_W-1:0] rsp_class
);

    localparam int WIDEST_KEEP = (HOST_KEEP > KERN_KEEP) ? HOST_KEEP : KERN_KEEP;

    sysreg_enc_t       enc;
    route_t            route;
    logic              wr_hyp;
    logic              wr_kern;
    logic [DATA_W-1:0] hyp_rd;
    logic [DATA_W-1:0] kern_rd;
    logic [DATA_W-1:0] rd_sel;

    assign enc = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};

    tcr_decode u_decode (
        .enc          (enc),
        .level        (req_level),
        .host_mode    (host_mode),
        .nested_virt  (nested_virt),
        .lvl2_enabled (lvl2_enabled),
        .route        (route)
    );

    assign wr_hyp  = req_valid && req_write && (route.target == TGT_HYP);
    assign wr_kern = req_valid && req_write && (route.target == TGT_KERN);

    tcr_regbank #(
        .DATA_W    (DATA_W),
        .HOST_KEEP (HOST_KEEP),
        .BASE_KEEP (BASE_KEEP),
        .KERN_KEEP (KERN_KEEP)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hyp    (wr_hyp),
        .wr_kern   (wr_kern),
        .wdata     (req_wdata),
        .host_mode (host_mode),
        .hyp_rd    (hyp_rd),
        .kern_rd   (kern_rd)
    );

    // Purpose: select read data; writes and faulting accesses return zero.
    always_comb begin
        rd_sel = '0;
        if (!req_write) begin
            unique case (route.target)
                TGT_HYP:  rd_sel = hyp_rd;
                TGT_KERN: rd_sel = kern_rd;
                default:  rd_sel = '0;
            endcase
        end
    end

    // Purpose: register the response one cycle after the request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_undef <= 1'b0;
            rsp_trap  <= 1'b0;
            rsp_class <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= req_valid ? rd_sel : '0;
            rsp_undef <= req_valid && route.undef;
            rsp_trap  <= req_valid && route.trap;
            rsp_class <= (req_valid && route.trap) ? CLASS_SYSREG_TRAP : '0;
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid);            // R2
    AST_RSP_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid);          // R2
    AST_USER_UNDEF:  assert property (@(posedge clk) disable iff (!rst_n)
                         (req_valid && req_level == 2'd0) |=> rsp_undef);                                     // R3
    AST_L1_TRAP:     assert property (@(posedge clk) disable iff (!rst_n)
                         (req_valid && req_level == 2'd1 && enc == ENC_HYPCTL && lvl2_enabled && nested_virt)
                         |=> (rsp_trap && rsp_class == CLASS_SYSREG_TRAP));                                  // R4
    AST_RSVD_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) (rsp_rdata >> WIDEST_KEEP) == '0);  // R9
    AST_FAULT_NODATA: assert property (@(posedge clk) disable iff (!rst_n)
                         (rsp_undef || rsp_trap) |-> rsp_rdata == '0);                                        // R12
    AST_FLAGS_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(rsp_undef && rsp_trap));          // R13
    AST_CLASS_TRAP:  assert property (@(posedge clk) disable iff (!rst_n) !rsp_trap |-> rsp_class == '0);     // R13

endmodule

// File: tb/tcr_file_test.sv
`timescale 1ns/1ps
module tcr_file_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_op0 = '0;
    logic [2:0]  req_op1 = '0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_op2 = '0;
    logic [1:0]  req_level = '0;
    logic [63:0] req_wdata = '0;
    logic        host_mode = 1'b0;
    logic        nested_virt = 1'b0;
    logic        lvl2_enabled = 1'b0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_undef;
    logic        rsp_trap;
    logic [5:0]  rsp_class;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [63:0] m_hyp = '0;
    logic [63:0] m_kern = '0;

    always #2.5 clk = ~clk;

    tcr_file uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_level(req_level), .req_wdata(req_wdata),
        .host_mode(host_mode), .nested_virt(nested_virt), .lvl2_enabled(lvl2_enabled),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef),
        .rsp_trap(rsp_trap), .rsp_class(rsp_class)
    );

    function automatic logic [63:0] keep(int n);
        return (64'd1 << n) - 64'd1;
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // sel: 0 = hypervisor encoding, 1 = kernel encoding, 2 = unmatched encoding
    task automatic access(int sel, bit wr, logic [1:0] lvl, logic [63:0] wd);
        bit e_undef = 0;
        bit e_trap = 0;
        logic [63:0] e_data = '0;
        int tgt = 0;
        string tag;
        if (sel == 2)        begin tag = "R11"; e_undef = 1; end
        else if (lvl == 0)   begin tag = "R3";  e_undef = 1; end
        else if (sel == 0) begin
            if (lvl == 1) begin
                tag = "R4";
                if (lvl2_enabled && nested_virt) e_trap = 1; else e_undef = 1;
            end else begin tag = "R6"; tgt = 1; end
        end else begin
            if (lvl == 1)      begin tag = "R5"; tgt = 2; end
            else if (lvl == 2) begin tag = "R7"; tgt = host_mode ? 1 : 2; end
            else               begin tag = "R8"; tgt = 2; end
        end
        if (e_undef || e_trap) tag = {tag, "/R12"};
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_level = lvl;
        req_wdata = wd;
        req_op0 = 2'd3; req_crn = 4'd14; req_crm = 4'd1;
        req_op1 = (sel == 0) ? 3'd4 : 3'd0;
        req_op2 = (sel == 2) ? 3'(1 + $urandom % 7) : 3'd0;
        if (tgt == 1) begin
            if (wr) m_hyp = wd & keep(host_mode ? 12 : 8);
            else    e_data = m_hyp & keep(host_mode ? 12 : 8);
        end else if (tgt == 2) begin
            if (wr) m_kern = wd & keep(10);
            else    e_data = m_kern & keep(10);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, "valid R2", {63'd0, rsp_valid}, 64'd1);
        check(tag, "undef R13", {63'd0, rsp_undef}, {63'd0, e_undef});
        check(tag, "trap R13", {63'd0, rsp_trap}, {63'd0, e_trap});
        check(tag, "class R13", {58'd0, rsp_class}, e_trap ? 64'h18 : 64'd0);
        check(tag, "rdata", rsp_rdata, e_data);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "valid in reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid after reset", {63'd0, rsp_valid}, 64'd0);

        // R1: reset contents, event enable bit clear
        host_mode = 1'b1;
        access(0, 0, 2'd2, '0);
        check("R1", "event enable bit", {63'd0, rsp_rdata[2]}, 64'd0);
        access(1, 0, 2'd3, '0);

        // R2: no response in the cycle after a response
        @(negedge clk);
        check("R2", "idle valid", {63'd0, rsp_valid}, 64'd0);

        // R9: host-mode write, read under both layouts
        access(0, 1, 2'd2, '1);
        access(0, 0, 2'd2, '0);               // expect 0xFFF
        host_mode = 1'b0;
        access(0, 0, 2'd3, '0);               // expect 0xFF
        access(0, 1, 2'd2, 64'hFFFF_FFFF_FFFF_FA5A);
        host_mode = 1'b1;
        access(0, 0, 2'd2, '0);               // bits 11:8 dropped: 0x5A

        // R10: kernel reserved bits
        access(1, 1, 2'd1, '1);
        access(1, 0, 2'd1, '0);               // expect 0x3FF

        // R7 / R8: redirection of the kernel encoding
        host_mode = 1'b1;
        access(1, 1, 2'd2, 64'h0000_0000_0000_0ABC);
        access(0, 0, 2'd3, '0);               // hypervisor register holds 0xABC
        access(1, 0, 2'd3, '0);               // kernel still 0x3FF
        host_mode = 1'b0;
        access(1, 1, 2'd2, 64'h155);
        access(1, 0, 2'd1, '0);               // kernel now 0x155
        host_mode = 1'b1;
        access(1, 1, 2'd3, 64'h2AA);
        access(1, 0, 2'd1, '0);               // R8: kernel 0x2AA

        // R4 / R12: trap and undefined leave state alone
        lvl2_enabled = 1'b1; nested_virt = 1'b1;
        access(0, 1, 2'd1, '0);
        lvl2_enabled = 1'b0;
        access(0, 1, 2'd1, '0);
        lvl2_enabled = 1'b1; nested_virt = 1'b0;
        access(0, 1, 2'd1, '0);
        access(0, 1, 2'd0, '0);               // R3
        access(1, 1, 2'd0, '0);               // R3
        access(2, 1, 2'd2, '0);               // R11
        access(0, 0, 2'd2, '0);               // unchanged 0xABC
        access(1, 0, 2'd3, '0);               // unchanged 0x2AA

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            host_mode    = 1'($urandom % 2);
            nested_virt  = 1'($urandom % 2);
            lvl2_enabled = 1'($urandom % 2);
            access(int'($urandom % 3), 1'($urandom % 2), 2'($urandom % 4),
                   {$urandom, $urandom});
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule